// File: doc/BRIEF.md
# BCD Timekeeper Register Window

This block is a real-time clock that presents its state as eight bytes at the top of a byte-wide address map. The lowest of the eight is a control byte. The seven above it hold the time in 24-hour BCD: seconds, minutes, hours, day of week, date, month and year. A free-running set of counters holds the real time. These counters advance on a one-pulse-per-second strobe. The bytes seen on the bus are only a shadow of those counters, and the whole shadow is refreshed from them in a single cycle.

Software has two ways to freeze the shadow. It sets a read-halt bit to get a stable snapshot while the counters keep running. It sets a write-halt bit to edit the shadow bytes. When the write-halt bit is cleared, the edited bytes are transferred into the counters. A stop flag in the seconds byte freezes the counters themselves. A flag in the day byte enables a frequency-test output, and it can only be changed through the write-halt procedure.

Top module: `rtc_window`

## Requirements
- R1: After reset the window reads, from offset 0 to 7: control 00h, seconds 80h (stop flag set), minutes 00h, hours 00h, day 01h, date 01h, month 01h, year 00h. While the stop flag is set, second strobes do not advance the time.
- R2: An access hits the window only when every address bit above the low three is 1. The low three bits select control (0), seconds (1), minutes (2), hours (3), day (4), date (5), month (6) or year (7). Outside the window `win_hit` is 0 and `rdata` is 00h, and writes change nothing.
- R3: Control bit 7 is the write-halt bit. While it is 1, bus writes land in the shadow bytes and the counters are untouched. A control write that clears it copies all seven shadow time bytes into the counters in that cycle.
- R4: Seconds and minutes wrap 59→00 and hours wrap 23→00, each carrying into the next field. The day of week (bits 2:0 of the day byte) counts 1..7 and wraps 7→1 at midnight.
- R5: The date rolls to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. Month 12 rolls to 01 and carries into the year, and year 99 rolls to 00.
- R6: In February the date rolls after 29 when the year is a multiple of 4 (00 included) and after 28 otherwise.
- R7: Control bit 6 is the read-halt bit. While it is 1, the shadow keeps the value it held when the halt was set, and the counters keep running. Once it is cleared, the next strobe shows the full count that accumulated meanwhile.
- R8: Bit 7 of the seconds byte is the stop flag. While it is 1 in the counters, strobes leave the time unchanged. It can be set or cleared only through the write-halt procedure.
- R9: When neither halt bit is set, a bus write to a time byte is seen in the shadow at once. It does not reach the counters and is overwritten by the next refresh.
- R10: `freq_test_en` follows bit 6 of the day byte held in the counters. A bus write of that bit with the write-halt bit clear leaves it unchanged.
- R11: The shadow is refreshed in the cycle after each strobe. A halt written in that same cycle does not cancel the refresh that is already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed window byte, 00h outside the window |
| win_hit | output | 1 | Address lies in the eight-byte window |
| freq_test_en | output | 1 | Frequency-test enable held in the counters |

## Verification
The bench uses the default 13-bit address width. This places the window at 1FF8h–1FFFh and puts addresses at 0FF8h and 0008h close by. Those neighbours alias the low offset bits but must not hit the window. Because the strobe is driven directly as an input, every carry chain can be reached in a single strobe after the time is loaded through the write-halt procedure. This covers midnight, the end of 30-day and 31-day months, February in leap and common years, and the end of the century. The same direct strobe lets the bench count precisely how many seconds pass during a read halt.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helpers for the timekeeper window.
// Assumes all time fields hold valid BCD.
package rtc_pkg;
    localparam int OFS_W = 3;

    typedef struct packed {
        logic [7:0] sec;    // [7] stop flag
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] day;    // [6] frequency-test enable, [2:0] day of week
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{sec: 8'h80, min: 8'h00, hour: 8'h00,
                                         day: 8'h01, date: 8'h01, month: 8'h01,
                                         year: 8'h00};

    // Add one to a two-digit BCD value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year divisible by 4: (10t + u) mod 4 == (2t + u) mod 4.
    function automatic logic is_leap(input logic [7:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return s[1:0] == 2'd0;
    endfunction

    // Last date of a BCD month in a BCD year.
    function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] y);
        case (mo)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Implemented bits of each window byte.
    function automatic logic [7:0] byte_mask(input logic [OFS_W-1:0] o);
        case (o)
            3'd2:    return 8'h7F;
            3'd3:    return 8'h3F;
            3'd4:    return 8'h47;
            3'd5:    return 8'h3F;
            3'd6:    return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/rtc_time_core.sv
// Real time counters. They advance on each strobe unless the stop flag is set.
// A load from the shadow takes priority over a strobe in the same cycle.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cnt
);
    rtc_time_t nxt;
    logic c_min, c_hr, c_day, c_mon, c_yr;

    // Compute the time one second later, carrying through every field.
    always_comb begin
        nxt   = cnt;
        c_min = cnt.sec[6:0] == 7'h59;
        c_hr  = c_min && (cnt.min == 8'h59);
        c_day = c_hr && (cnt.hour == 8'h23);
        c_mon = c_day && (cnt.date == month_last(cnt.month, cnt.year));
        c_yr  = c_mon && (cnt.month == 8'h12);
        nxt.sec = c_min ? 8'h00 : bcd_inc(cnt.sec);
        if (c_min) nxt.min  = c_hr  ? 8'h00 : bcd_inc(cnt.min);
        if (c_hr)  nxt.hour = c_day ? 8'h00 : bcd_inc(cnt.hour);
        if (c_day) begin
            nxt.day[2:0] = (cnt.day[2:0] == 3'd7) ? 3'd1 : cnt.day[2:0] + 3'd1;
            nxt.date     = c_mon ? 8'h01 : bcd_inc(cnt.date);
        end
        if (c_mon) nxt.month = c_yr ? 8'h01 : bcd_inc(cnt.month);
        if (c_yr)  nxt.year  = (cnt.year == 8'h99) ? 8'h00 : bcd_inc(cnt.year);
    end

    // Counter register: reset, load from the shadow, or advance one second.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= TIME_RESET;
        else if (load)               cnt <= load_val;
        else if (tick && !cnt.sec[7]) cnt <= nxt;
    end
endmodule

// File: rtl/rtc_shadow_regs.sv
// Bus-visible shadow bytes and control byte. The shadow is refreshed from the
// counters in the cycle after each strobe unless a halt bit is set. Clearing the
// write-halt bit raises load for one cycle.
module rtc_shadow_regs
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [OFS_W-1:0] ofs,
    input  logic [7:0]       wdata,
    input  rtc_time_t        cnt,
    output rtc_time_t        vis,
    output logic [7:0]       ctrl,
    output logic             load
);
    logic       tick_d;
    logic       copy;
    logic [7:0] wm;

    assign copy = tick_d && !ctrl[7] && !ctrl[6];
    assign load = wr && (ofs == '0) && ctrl[7] && !wdata[7];
    assign wm   = wdata & byte_mask(ofs);

    // Delay the strobe so the refresh sees the counters after they advance.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_d <= 1'b0;
        else        tick_d <= tick;
    end

    // Control byte: written directly from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ctrl <= 8'h00;
        else if (wr && (ofs == '0))    ctrl <= wdata;
    end

    // Shadow bytes: a whole-set refresh wins over a bus write to a single byte.
    always_ff @(posedge clk) begin
        if (!rst_n) vis <= TIME_RESET;
        else if (copy) vis <= cnt;
        else if (wr) begin
            case (ofs)
                3'd1:    vis.sec   <= wm;
                3'd2:    vis.min   <= wm;
                3'd3:    vis.hour  <= wm;
                3'd4:    vis.day   <= wm;
                3'd5:    vis.date  <= wm;
                3'd6:    vis.month <= wm;
                3'd7:    vis.year  <= wm;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rtc_window.sv
// Top of the timekeeper window: decodes the top eight addresses, muxes the read
// data and ties the shadow to the counters. Assumes one write per cycle at most.
module rtc_window
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              win_hit,
    output logic              freq_test_en
);
    localparam int BASE_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] ofs;
    logic             wr_hit;
    logic             shadow_load;
    logic [7:0]       ctrl_byte;
    logic [7:0]       sel;
    rtc_time_t        cnt_time;
    rtc_time_t        vis_time;

    assign ofs          = addr[OFS_W-1:0];
    assign win_hit      = &addr[ADDR_W-1:ADDR_W-BASE_W];
    assign wr_hit       = wr_en && win_hit;
    assign freq_test_en = cnt_time.day[6];

    rtc_shadow_regs u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_1hz),
        .wr    (wr_hit),
        .ofs   (ofs),
        .wdata (wdata),
        .cnt   (cnt_time),
        .vis   (vis_time),
        .ctrl  (ctrl_byte),
        .load  (shadow_load)
    );

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .load     (shadow_load),
        .load_val (vis_time),
        .cnt      (cnt_time)
    );

    // Read mux over the eight window bytes.
    always_comb begin
        case (ofs)
            3'd0:    sel = ctrl_byte;
            3'd1:    sel = vis_time.sec;
            3'd2:    sel = vis_time.min;
            3'd3:    sel = vis_time.hour;
            3'd4:    sel = vis_time.day;
            3'd5:    sel = vis_time.date;
            3'd6:    sel = vis_time.month;
            default: sel = vis_time.year;
        endcase
        rdata = win_hit ? sel : 8'h00;
    end
endmodule

// File: rtl/rtc_window_chk.sv
// Checker for the timekeeper window, bound to every rtc_window instance.
// Field slices follow the time struct: sec [55:48] ... year [7:0].
module rtc_window_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        load,
    input logic        wr_hit,
    input logic [7:0]  ctrl,
    input logic [55:0] cnt,
    input logic [55:0] vis
);
    assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(vis));

    assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt[55:48] == 8'h59) |=> cnt[54:48] == 7'h00);

    assert_april_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt[55:48] == 8'h59 && cnt[47:40] == 8'h59 &&
         cnt[39:32] == 8'h23 && cnt[23:16] == 8'h30 && cnt[15:8] == 8'h04)
        |=> (cnt[23:16] == 8'h01 && cnt[15:8] == 8'h05));

    assert_read_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[6] && !wr_hit) |=> $stable(vis));

    assert_stop_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[55] && !load) |=> $stable(cnt));

    assert_idle_counters_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
endmodule

bind rtc_window rtc_window_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_1hz),
    .load   (shadow_load),
    .wr_hit (wr_hit),
    .ctrl   (ctrl_byte),
    .cnt    (cnt_time),
    .vis    (vis_time)
);

// File: tb/tb_rtc_window.sv
// Directed bench for rtc_window: one task per scenario, each checking its results.
module tb_rtc_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic [12:0] addr = 13'h1FF8;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        win_hit;
    logic        freq_test_en;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    rtc_window #(.ADDR_W(13)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .win_hit(win_hit),
        .freq_test_en(freq_test_en)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr_byte(input logic [2:0] o, input logic [7:0] d);
        @(negedge clk);
        addr = {10'h3FF, o}; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_byte(input string tag, input logic [2:0] o, input logic [7:0] exp);
        addr = {10'h3FF, o};
        #1;
        check(tag, rdata, exp);
    endtask

    // One strobe, then one more cycle so the refresh has landed.
    task automatic tick1();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, m, h, dy, dt, mo, y);
        wr_byte(0, 8'h80);
        wr_byte(1, s); wr_byte(2, m); wr_byte(3, h); wr_byte(4, dy);
        wr_byte(5, dt); wr_byte(6, mo); wr_byte(7, y);
        wr_byte(0, 8'h00);
    endtask

    task automatic t_reset_r1();
        logic [7:0] exp [8] = '{8'h00, 8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        for (int i = 0; i < 8; i++) expect_byte("R1 reset byte", 3'(i), exp[i]);
        tick1();
        expect_byte("R1 stopped after reset", 1, 8'h80);
    endtask

    task automatic t_decode_r2();
        addr = 13'h0008; #1;
        check("R2 hit outside", {7'd0, win_hit}, 8'h00);
        check("R2 rdata outside", rdata, 8'h00);
        @(negedge clk); addr = 13'h0FF8; wdata = 8'hFF; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        expect_byte("R2 alias write ignored", 0, 8'h00);
        check("R2 hit inside", {7'd0, win_hit}, 8'h01);
    endtask

    task automatic t_set_r3();
        set_time(8'h10, 8'h20, 8'h12, 8'h03, 8'h15, 8'h06, 8'h21);
        expect_byte("R3 shadow holds written", 1, 8'h10);
        tick1();
        expect_byte("R3 seconds after load", 1, 8'h11);
        expect_byte("R3 date after load", 5, 8'h15);
    endtask

    task automatic t_midnight_r4();
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h10, 8'h03, 8'h21);
        tick1();
        expect_byte("R4 sec", 1, 8'h00);
        expect_byte("R4 min", 2, 8'h00);
        expect_byte("R4 hour", 3, 8'h00);
        expect_byte("R4 dow wrap", 4, 8'h01);
        expect_byte("R4 date", 5, 8'h11);
    endtask

    task automatic t_months_r5();
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h21);
        tick1();
        expect_byte("R5 30-day date", 5, 8'h01);
        expect_byte("R5 30-day month", 6, 8'h05);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h01, 8'h21);
        tick1();
        expect_byte("R5 31-day month", 6, 8'h02);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h31, 8'h12, 8'h99);
        tick1();
        expect_byte("R5 year wrap", 7, 8'h00);
        expect_byte("R5 month wrap", 6, 8'h01);
    endtask

    task automatic t_feb_r6();
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        tick1();
        expect_byte("R6 leap 29th", 5, 8'h29);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
        tick1();
        expect_byte("R6 leap to march", 6, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
        tick1();
        expect_byte("R6 common to march", 6, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
        tick1();
        expect_byte("R6 year 00 leap", 5, 8'h29);
    endtask

    task automatic t_read_halt_r7();
        set_time(8'h00, 8'h00, 8'h08, 8'h01, 8'h01, 8'h01, 8'h21);
        tick1();
        wr_byte(0, 8'h40);
        tick1(); tick1(); tick1();
        expect_byte("R7 frozen", 1, 8'h01);
        wr_byte(0, 8'h00);
        tick1();
        expect_byte("R7 caught up", 1, 8'h05);
    endtask

    task automatic t_halt_race_r11();
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        addr = 13'h1FF8; wdata = 8'h40; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        expect_byte("R11 refresh survives halt", 1, 8'h06);
        tick1();
        expect_byte("R11 halted", 1, 8'h06);
        wr_byte(0, 8'h00);
        tick1();
        expect_byte("R11 resumed", 1, 8'h08);
    endtask

    task automatic t_stop_r8();
        set_time(8'h85, 8'h10, 8'h08, 8'h01, 8'h01, 8'h01, 8'h21);
        tick1(); tick1();
        expect_byte("R8 stopped", 1, 8'h85);
        wr_byte(0, 8'h80); wr_byte(1, 8'h05); wr_byte(0, 8'h00);
        tick1();
        expect_byte("R8 restarted", 1, 8'h06);
    endtask

    task automatic t_bus_write_r9();
        wr_byte(2, 8'h45);
        expect_byte("R9 shadow write seen", 2, 8'h45);
        tick1();
        expect_byte("R9 overwritten", 2, 8'h10);
        expect_byte("R9 seconds", 1, 8'h07);
    endtask

    task automatic t_freq_r10();
        check("R10 ft clear", {7'd0, freq_test_en}, 8'h00);
        wr_byte(4, 8'h43);
        check("R10 ft plain write ignored", {7'd0, freq_test_en}, 8'h00);
        wr_byte(0, 8'h80); wr_byte(4, 8'h43); wr_byte(0, 8'h00);
        check("R10 ft set", {7'd0, freq_test_en}, 8'h01);
        tick1();
        expect_byte("R10 day byte", 4, 8'h43);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_decode_r2();
        t_set_r3();
        t_midnight_r4();
        t_months_r5();
        t_feb_r6();
        t_read_halt_r7();
        t_halt_race_r11();
        t_stop_r8();
        t_bus_write_r9();
        t_freq_r10();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end
endmodule